// File: doc/BRIEF.md
# Program Counter and Stack Pointer Unit

This block works out where an 8-bit controller goes next and keeps its byte-wide stack pointer. On each step it is given the address of the current instruction, the instruction length, a branch kind, a taken flag and the operand bytes. From these it produces the next fetch address. The kinds are fall-through, signed relative, paged 11-bit absolute, full 16-bit and indexed by accumulator plus data pointer. In the same step it forms an address for reading a constant from code space, either data pointer plus accumulator or advanced PC plus accumulator. It also carries out at most one single-byte stack push or pop.

A call is sequenced by the surrounding controller as two pushes: the low byte of the return address and then the high byte. A return is two pops, high and then low. The popped bytes come back as the operand bytes of a long-kind step. Fetch, decode, condition evaluation and the memories themselves sit outside. The block's outputs are registered, so the controller sees the results of a step on the next clock.

Top module: `pcsp_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `next_pc` becomes 0x0000, `sp` becomes 0x07, `stk_addr`, `tbl_addr` and `stk_wdata` become zero, and `out_valid` becomes 0.
- R2: The advanced PC is `cur_pc + instr_len` modulo 2^16. With `br_taken` low, or with `br_kind` 0 (none) or 5 to 7, `next_pc` is the advanced PC. Kinds: 0 none, 1 relative, 2 absolute-11, 3 long, 4 indexed.
- R3: A taken relative branch (kind 1) gives the advanced PC plus the sign-extended offset byte, modulo 2^16. The offset byte is `op2` when `instr_len` is 3 and `op1` otherwise.
- R4: A taken absolute-11 branch (kind 2) gives {advanced PC bits 15..11, `page_bits`, `op1`}. The upper five bits come from the advanced PC, not from `cur_pc`.
- R5: A taken long branch (kind 3) gives {`op1`, `op2`}, with `op1` as the high byte.
- R6: A taken indexed branch (kind 4) gives `dptr` plus zero-extended `acc`, modulo 2^16.
- R7: `tbl_addr` is the advanced PC plus zero-extended `acc` when `tbl_use_pc` is 1, and `dptr` plus zero-extended `acc` when it is 0, modulo 2^16.
- R8: A push first increments `sp` modulo 256 (0xFF goes to 0x00). `stk_addr` becomes the new `sp`. `stk_wdata` becomes the high byte of the advanced PC when `push_hi` is 1, and the low byte otherwise.
- R9: A pop (without push) sets `stk_addr` to the old `sp` and then decrements `sp` modulo 256 (0x00 goes to 0xFF).
- R10: When push and pop are requested in the same step, only the push takes effect.
- R11: The results of a step with `step_valid` high appear one clock later with `out_valid` high. A cycle with `step_valid` low drives `out_valid` low on the next clock and leaves `next_pc`, `tbl_addr`, `sp`, `stk_addr` and `stk_wdata` unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Inputs of this cycle form a step |
| cur_pc | input | 16 | Address of the current instruction |
| instr_len | input | 2 | Instruction length in bytes, 1 to 3 |
| br_kind | input | 3 | Branch kind (0 none, 1 relative, 2 absolute-11, 3 long, 4 indexed) |
| br_taken | input | 1 | Branch condition outcome |
| page_bits | input | 3 | Top three opcode bits for an absolute-11 target |
| op1 | input | 8 | First operand byte |
| op2 | input | 8 | Second operand byte |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| tbl_use_pc | input | 1 | Table read based on advanced PC (1) or data pointer (0) |
| push_req | input | 1 | Push one byte |
| pop_req | input | 1 | Pop one byte |
| push_hi | input | 1 | Push the high (1) or low (0) return-address byte |
| next_pc | output | 16 | Next fetch address |
| tbl_addr | output | 16 | Code-space table read address |
| stk_addr | output | 8 | Stack memory address for this push or pop |
| stk_wdata | output | 8 | Byte to write on a push |
| sp | output | 8 | Stack pointer |
| out_valid | output | 1 | Outputs reflect a step |

## Verification
Each result is due on the clock that follows the step: `next_pc` (R2 to R6), `tbl_addr` (R7), `sp`, `stk_addr` and `stk_wdata` (R8 to R10) and `out_valid` (R11). The bench applies a step just after a falling edge. It then compares every output at the next falling edge, which is the first settled point after the registering rising edge, and only then drives the next step. Idle cycles are compared against the values carried over from the previous step, so a hold fault or a stray stack update shows up within the same cycle.

// File: rtl/pcsp_pkg.sv
package pcsp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int PAGE_W = BYTE_W + 3;
  localparam int LEN_W  = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    BR_NONE = 3'd0,
    BR_REL  = 3'd1,
    BR_ABS  = 3'd2,
    BR_LONG = 3'd3,
    BR_IDX  = 3'd4
  } br_kind_e;
endpackage

// File: rtl/pcsp_target.sv
module pcsp_target
  import pcsp_pkg::*;
(
  input  addr_t               seq_pc,
  input  logic [LEN_W-1:0]    ilen,
  input  logic [2:0]          kind,
  input  logic                taken,
  input  logic [2:0]          page_bits,
  input  byte_t               op1,
  input  byte_t               op2,
  input  byte_t               acc,
  input  addr_t               dptr,
  output addr_t               target
);
  localparam int EXT_W = ADDR_W - BYTE_W;

  byte_t rel_byte;
  addr_t rel_tgt;
  addr_t abs_tgt;
  addr_t long_tgt;
  addr_t idx_tgt;

  // the offset is always the last byte of the instruction
  assign rel_byte = (ilen == LEN_W'(3)) ? op2 : op1;
  assign rel_tgt  = seq_pc + {{EXT_W{rel_byte[BYTE_W-1]}}, rel_byte};
  assign abs_tgt  = {seq_pc[ADDR_W-1:PAGE_W], page_bits, op1};
  assign long_tgt = {op1, op2};
  assign idx_tgt  = dptr + {{EXT_W{1'b0}}, acc};

  always_comb begin
    target = seq_pc;
    if (taken) begin
      case (br_kind_e'(kind))
        BR_REL:  target = rel_tgt;
        BR_ABS:  target = abs_tgt;
        BR_LONG: target = long_tgt;
        BR_IDX:  target = idx_tgt;
        default: target = seq_pc;
      endcase
    end
  end
endmodule

// File: rtl/pcsp_table.sv
module pcsp_table
  import pcsp_pkg::*;
(
  input  addr_t seq_pc,
  input  addr_t dptr,
  input  byte_t acc,
  input  logic  use_pc,
  output addr_t addr
);
  localparam int EXT_W = ADDR_W - BYTE_W;

  addr_t base;
  assign base = use_pc ? seq_pc : dptr;
  assign addr = base + {{EXT_W{1'b0}}, acc};
endmodule

// File: rtl/pcsp_stack.sv
module pcsp_stack
  import pcsp_pkg::*;
#(
  parameter byte_t SP_INIT = 8'h07
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  push,
  input  logic  pop,
  output byte_t sp_q,
  output byte_t addr_q
);
  byte_t sp_inc;
  byte_t sp_dec;

  assign sp_inc = sp_q + byte_t'(1);
  assign sp_dec = sp_q - byte_t'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= SP_INIT;
      addr_q <= '0;
    end else if (en) begin
      if (push) begin
        sp_q   <= sp_inc;
        addr_q <= sp_inc;
      end else if (pop) begin
        sp_q   <= sp_dec;
        addr_q <= sp_q;
      end
    end
  end
endmodule

// File: rtl/pcsp_unit.sv
module pcsp_unit
  import pcsp_pkg::*;
#(
  parameter logic [7:0] SP_INIT = 8'h07
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step_valid,
  input  logic [15:0] cur_pc,
  input  logic [1:0]  instr_len,
  input  logic [2:0]  br_kind,
  input  logic        br_taken,
  input  logic [2:0]  page_bits,
  input  logic [7:0]  op1,
  input  logic [7:0]  op2,
  input  logic [7:0]  acc,
  input  logic [15:0] dptr,
  input  logic        tbl_use_pc,
  input  logic        push_req,
  input  logic        pop_req,
  input  logic        push_hi,
  output logic [15:0] next_pc,
  output logic [15:0] tbl_addr,
  output logic [7:0]  stk_addr,
  output logic [7:0]  stk_wdata,
  output logic [7:0]  sp,
  output logic        out_valid
);
  addr_t seq_pc;
  addr_t tgt_d;
  addr_t tbl_d;
  byte_t wdata_d;

  assign seq_pc  = cur_pc + addr_t'(instr_len);
  assign wdata_d = push_hi ? seq_pc[ADDR_W-1:BYTE_W] : seq_pc[BYTE_W-1:0];

  pcsp_target i_target (
    .seq_pc    (seq_pc),
    .ilen      (instr_len),
    .kind      (br_kind),
    .taken     (br_taken),
    .page_bits (page_bits),
    .op1       (op1),
    .op2       (op2),
    .acc       (acc),
    .dptr      (dptr),
    .target    (tgt_d)
  );

  pcsp_table i_table (
    .seq_pc (seq_pc),
    .dptr   (dptr),
    .acc    (acc),
    .use_pc (tbl_use_pc),
    .addr   (tbl_d)
  );

  pcsp_stack #(.SP_INIT(SP_INIT)) i_stack (
    .clk    (clk),
    .rst    (rst),
    .en     (step_valid),
    .push   (push_req),
    .pop    (pop_req),
    .sp_q   (sp),
    .addr_q (stk_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc   <= '0;
      tbl_addr  <= '0;
      stk_wdata <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= step_valid;
      if (step_valid) begin
        next_pc  <= tgt_d;
        tbl_addr <= tbl_d;
        if (push_req) stk_wdata <= wdata_d;
      end
    end
  end
endmodule

// File: rtl/pcsp_checker.sv
module pcsp_checker
  import pcsp_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        step_valid,
  input logic [15:0] cur_pc,
  input logic [1:0]  instr_len,
  input logic [2:0]  br_kind,
  input logic        br_taken,
  input logic [7:0]  op1,
  input logic [7:0]  op2,
  input logic        push_req,
  input logic        pop_req,
  input logic [15:0] next_pc,
  input logic [7:0]  stk_addr,
  input logic [7:0]  sp,
  input logic        out_valid
);
  // R2 fall-through
  p_fall_through_r2: assert property (@(posedge clk) disable iff (rst)
    (step_valid && (!br_taken || br_kind == 3'd0))
    |=> next_pc == $past(cur_pc) + addr_t'($past(instr_len)));

  // R4 page bits kept from advanced PC
  p_abs_page_r4: assert property (@(posedge clk) disable iff (rst)
    (step_valid && br_taken && br_kind == 3'd2)
    |=> next_pc[15:11] == (($past(cur_pc) + addr_t'($past(instr_len))) >> 11));

  // R5 long target
  p_long_r5: assert property (@(posedge clk) disable iff (rst)
    (step_valid && br_taken && br_kind == 3'd3)
    |=> next_pc == {$past(op1), $past(op2)});

  // R8 pre-increment push
  p_push_r8: assert property (@(posedge clk) disable iff (rst)
    (step_valid && push_req)
    |=> (sp == $past(sp) + 8'd1) && (stk_addr == sp));

  // R9 pop reads old SP
  p_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (step_valid && pop_req && !push_req)
    |=> (stk_addr == $past(sp)) && (sp == $past(sp) - 8'd1));

  // R11 idle holds
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !step_valid |=> !out_valid && $stable(sp) && $stable(next_pc) && $stable(stk_addr));
endmodule

bind pcsp_unit pcsp_checker i_pcsp_checker (
  .clk        (clk),
  .rst        (rst),
  .step_valid (step_valid),
  .cur_pc     (cur_pc),
  .instr_len  (instr_len),
  .br_kind    (br_kind),
  .br_taken   (br_taken),
  .op1        (op1),
  .op2        (op2),
  .push_req   (push_req),
  .pop_req    (pop_req),
  .next_pc    (next_pc),
  .stk_addr   (stk_addr),
  .sp         (sp),
  .out_valid  (out_valid)
);

// File: tb/test_pcsp_unit.sv
module test_pcsp_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_valid = 1'b0;
  logic [15:0] cur_pc = '0;
  logic [1:0]  instr_len = 2'd1;
  logic [2:0]  br_kind = '0;
  logic        br_taken = 1'b0;
  logic [2:0]  page_bits = '0;
  logic [7:0]  op1 = '0, op2 = '0, acc = '0;
  logic [15:0] dptr = '0;
  logic        tbl_use_pc = 1'b0, push_req = 1'b0, pop_req = 1'b0, push_hi = 1'b0;
  logic [15:0] next_pc, tbl_addr;
  logic [7:0]  stk_addr, stk_wdata, sp;
  logic        out_valid;

  int nchk = 0;
  int nerr = 0;

  logic [15:0] m_pc = '0, m_tbl = '0;
  logic [7:0]  m_sp = 8'h07, m_addr = '0, m_wd = '0;

  always #10 clk = ~clk;

  pcsp_unit i_pcsp_unit (
    .clk(clk), .rst(rst), .step_valid(step_valid), .cur_pc(cur_pc),
    .instr_len(instr_len), .br_kind(br_kind), .br_taken(br_taken),
    .page_bits(page_bits), .op1(op1), .op2(op2), .acc(acc), .dptr(dptr),
    .tbl_use_pc(tbl_use_pc), .push_req(push_req), .pop_req(pop_req),
    .push_hi(push_hi), .next_pc(next_pc), .tbl_addr(tbl_addr),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .sp(sp), .out_valid(out_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] f_seq();
    return cur_pc + {14'd0, instr_len};
  endfunction

  function automatic logic [15:0] f_pc();
    logic [15:0] s;
    logic [7:0]  o;
    s = f_seq();
    if (!br_taken) return s;
    case (br_kind)
      3'd1: begin
        o = (instr_len == 2'd3) ? op2 : op1;
        return s + {{8{o[7]}}, o};
      end
      3'd2: return {s[15:11], page_bits, op1};
      3'd3: return {op1, op2};
      3'd4: return dptr + {8'd0, acc};
      default: return s;
    endcase
  endfunction

  function automatic string f_tag();
    if (!br_taken) return "R2";
    case (br_kind)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R2";
    endcase
  endfunction

  // inputs are already set; advance one clock and compare every output
  task automatic run_step();
    string t;
    t = f_tag();
    if (step_valid) begin
      m_pc  = f_pc();
      m_tbl = (tbl_use_pc ? f_seq() : dptr) + {8'd0, acc};
      if (push_req) begin
        m_sp   = m_sp + 8'd1;
        m_addr = m_sp;
        m_wd   = push_hi ? f_seq() >> 8 : f_seq() & 16'h00FF;
      end else if (pop_req) begin
        m_addr = m_sp;
        m_sp   = m_sp - 8'd1;
      end
    end
    @(negedge clk);
    if (!step_valid) t = "R11";
    chk({t, " next_pc"}, 32'(next_pc), 32'(m_pc));
    chk(step_valid ? "R7 tbl_addr" : "R11 tbl_addr", 32'(tbl_addr), 32'(m_tbl));
    chk((push_req && pop_req) ? "R10 sp" : "R8/R9 sp", 32'(sp), 32'(m_sp));
    chk("R9 stk_addr", 32'(stk_addr), 32'(m_addr));
    chk("R8 stk_wdata", 32'(stk_wdata), 32'(m_wd));
    chk("R11 out_valid", 32'(out_valid), 32'(step_valid));
  endtask

  task automatic clear_in();
    step_valid = 1'b1; br_taken = 1'b0; br_kind = 3'd0;
    push_req = 1'b0; pop_req = 1'b0; push_hi = 1'b0; tbl_use_pc = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 next_pc", 32'(next_pc), 32'h0);
    chk("R1 sp", 32'(sp), 32'h07);
    chk("R1 out_valid", 32'(out_valid), 32'h0);
    chk("R1 stk_addr", 32'(stk_addr), 32'h0);
    rst = 1'b0;

    // R2 fall-through wraps
    clear_in(); cur_pc = 16'hFFFE; instr_len = 2'd3; run_step();
    // R3 backward offset across zero, two-byte form
    clear_in(); cur_pc = 16'h0000; instr_len = 2'd2; br_kind = 3'd1; br_taken = 1'b1;
    op1 = 8'h80; op2 = 8'h11; run_step();
    chk("R3 wrap value", 32'(next_pc), 32'hFF82);
    // R3 three-byte form uses the last byte
    clear_in(); cur_pc = 16'h1000; instr_len = 2'd3; br_kind = 3'd1; br_taken = 1'b1;
    op1 = 8'h7F; op2 = 8'h05; run_step();
    chk("R3 last byte", 32'(next_pc), 32'h1008);
    // R4 page taken from the advanced PC at a page edge
    clear_in(); cur_pc = 16'h07FF; instr_len = 2'd2; br_kind = 3'd2; br_taken = 1'b1;
    page_bits = 3'b101; op1 = 8'h3C; run_step();
    chk("R4 page edge", 32'(next_pc), 32'h0D3C);
    // R6 indexed and R7 both table bases
    clear_in(); dptr = 16'hFFF0; acc = 8'h20; br_kind = 3'd4; br_taken = 1'b1; run_step();
    clear_in(); cur_pc = 16'h00FF; instr_len = 2'd1; acc = 8'hFF; tbl_use_pc = 1'b1; run_step();
    // R9 pop then R8 push with R10 collision
    clear_in(); pop_req = 1'b1; run_step();
    clear_in(); push_req = 1'b1; pop_req = 1'b1; push_hi = 1'b1; cur_pc = 16'hAB00; run_step();
    // R8 wrap 0xFF -> 0x00
    while (m_sp != 8'hFF) begin clear_in(); push_req = 1'b1; run_step(); end
    clear_in(); push_req = 1'b1; run_step();
    chk("R8 sp wrap", 32'(sp), 32'h00);
    // R9 wrap 0x00 -> 0xFF
    clear_in(); pop_req = 1'b1; run_step();
    chk("R9 sp wrap", 32'(sp), 32'hFF);
    // R11 idle with busy inputs
    clear_in(); step_valid = 1'b0; push_req = 1'b1; br_taken = 1'b1; br_kind = 3'd3;
    op1 = 8'h55; run_step();

    for (int i = 0; i < 400; i++) begin
      step_valid = ($urandom % 8) != 0;
      cur_pc     = 16'($urandom);
      instr_len  = 2'($urandom % 3 + 1);
      br_kind    = 3'($urandom % 6);
      br_taken   = 1'($urandom);
      page_bits  = 3'($urandom);
      op1 = 8'($urandom); op2 = 8'($urandom); acc = 8'($urandom);
      dptr       = 16'($urandom);
      tbl_use_pc = 1'($urandom);
      push_req   = ($urandom % 3) == 0;
      pop_req    = ($urandom % 3) == 0;
      push_hi    = 1'($urandom);
      run_step();
    end

    // R1 reset mid-run restores SP
    rst = 1'b1; @(negedge clk);
    chk("R1 sp again", 32'(sp), 32'h07);
    chk("R1 next_pc again", 32'(next_pc), 32'h0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule